// File: doc/BRIEF.md
# Serial NOR Flash Read Responder

This block behaves as the slave side of a serial NOR flash that only knows how to be read. A host drives a chip select (active low), a serial clock and a command line. The block answers on its single data-out line with the contents of a small internal byte array. The array is filled through a parallel write port before the host starts reading, which makes the block suitable as a boot-image source in system-level benches and on prototyping hardware.

Each transaction begins with an 8-bit command and a 24-bit start address. Only the plain read and, optionally, the fast read with one dummy byte are recognised. After a read command the block streams bytes with an address that increments on its own, until chip select goes high. Any other command makes the block stay silent for the rest of that selection.

All serial logic runs on a fast system clock. The serial clock, chip select and command line are first passed through a synchronizer, and serial clock edges are found by comparing successive synchronized samples.

Top module: `spi_flash_responder`

## Requirements
- R1: While chip select is high, and from reset onward, the data-out line `miso` is held at 0; once `cs_n` has been high for 8 system clocks, `miso` reads 0.
- R2: Command 0x03 followed by a 24-bit address (both sent MSB first, `mosi` sampled on SCK rising edges) makes the first data byte at that address appear MSB first. Its first bit is valid at the SCK rising edge right after the last address bit, with no dummy clocks.
- R3: Reading continues past byte boundaries: each further group of 8 SCK clocks returns the byte at the next address.
- R4: The internal address is taken modulo `MEM_BYTES` (256 by default). Upper address bits are ignored, and reading past the last byte wraps to byte 0.
- R5: Command 0x0B (enabled when `FAST_READ_EN` is 1) inserts 8 dummy SCK clocks after the address, during which `miso` is 0. The data then follows as in R2 and R3.
- R6: Any other command value leaves `miso` at 0 for the rest of the selection. The next selection is decoded normally.
- R7: Raising `cs_n` at any point ends the transaction and clears all bit and byte progress, so the next selection starts again with a command.
- R8: A system clock cycle with `pl_we` high stores `pl_data` at byte `pl_addr`, and later reads return the stored value.
- R9: `miso` changes only after SCK falling edges and stays stable while SCK is high (SPI mode 0). Each SCK phase must last at least `SYNC_STAGES`+2 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idles low |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial command and address from the host |
| miso | output | 1 | Serial read data to the host |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | ADDR_W | Preload byte address |
| pl_data | input | 8 | Preload byte value |

## Verification
Byte values in the array are a scrambled function of the address, so a wrong start address, a skipped increment or a bit-order swap each produce a different byte. Reads start at address 0, at odd addresses, just below the top of the array (to show wrap) and with non-zero upper address bits (to show truncation), using both the plain and the fast command. Separate cases use an unknown command (silence, then normal recovery), chip select raised in the middle of a byte (a fresh start, not a continuation), and a preload overwrite, to show that reads come from the array as it is now.

// File: rtl/spi_flash_responder.sv
module spi_flash_responder #(
  parameter int MEM_BYTES    = 256,
  parameter int SYNC_STAGES  = 2,
  parameter bit FAST_READ_EN = 1'b1,
  localparam int ADDR_W      = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              pl_we,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [7:0]        pl_data
);

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;

  typedef enum logic [2:0] {ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_IGNORE} st_t;

  logic [SYNC_STAGES-1:0] sck_sy, cs_sy, mo_sy;
  logic                   sck_d;
  st_t                    state;
  logic [4:0]             cnt;
  logic [23:0]            sh;
  logic [ADDR_W-1:0]      addr;
  logic [6:0]             dsh;
  logic                   fast;
  logic [7:0]             mem [MEM_BYTES];

  wire        sck_s    = sck_sy[SYNC_STAGES-1];
  wire        selected = ~cs_sy[SYNC_STAGES-1];
  wire        mo_s     = mo_sy[SYNC_STAGES-1];
  wire        sck_rise = sck_s & ~sck_d;
  wire        sck_fall = ~sck_s & sck_d;
  wire [23:0] sh_nx    = {sh[22:0], mo_s};
  wire [7:0]  rd       = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      cs_sy  <= '1;
      mo_sy  <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[SYNC_STAGES-2:0], sck};
      cs_sy  <= {cs_sy[SYNC_STAGES-2:0], cs_n};
      mo_sy  <= {mo_sy[SYNC_STAGES-2:0], mosi};
      sck_d  <= sck_s;
    end
  end

  always_ff @(posedge clk) begin
    if (pl_we) mem[pl_addr] <= pl_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CMD;
      cnt   <= '0;
      sh    <= '0;
      addr  <= '0;
      dsh   <= '0;
      fast  <= 1'b0;
      miso  <= 1'b0;
    end else if (!selected) begin
      state <= ST_CMD;
      cnt   <= '0;
      fast  <= 1'b0;
      miso  <= 1'b0;
    end else begin
      if (sck_rise) begin
        case (state)
          ST_CMD: begin
            sh <= sh_nx;
            if (cnt == 5'd7) begin
              cnt <= '0;
              if (sh_nx[7:0] == OP_READ) begin
                state <= ST_ADDR;
                fast  <= 1'b0;
              end else if (FAST_READ_EN && sh_nx[7:0] == OP_FAST) begin
                state <= ST_ADDR;
                fast  <= 1'b1;
              end else begin
                state <= ST_IGNORE;
              end
            end else begin
              cnt <= cnt + 5'd1;
            end
          end
          ST_ADDR: begin
            sh <= sh_nx;
            if (cnt == 5'd23) begin
              cnt   <= '0;
              addr  <= sh_nx[ADDR_W-1:0];
              state <= fast ? ST_DUMMY : ST_DATA;
            end else begin
              cnt <= cnt + 5'd1;
            end
          end
          ST_DUMMY: begin
            if (cnt == 5'd7) begin
              cnt   <= '0;
              state <= ST_DATA;
            end else begin
              cnt <= cnt + 5'd1;
            end
          end
          default: ;
        endcase
      end
      if (sck_fall && state == ST_DATA) begin
        if (cnt[2:0] == 3'd0) begin
          miso <= rd[7];
          dsh  <= rd[6:0];
          addr <= addr + 1'b1;
        end else begin
          miso <= dsh[6];
          dsh  <= {dsh[5:0], 1'b0};
        end
        cnt <= cnt + 5'd1;
      end
    end
  end

endmodule

// File: rtl/spi_flash_responder_chk.sv
module spi_flash_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       cs_n,
  input logic       miso,
  input logic [2:0] st
);

  localparam logic [2:0] S_CMD = 3'd0, S_ADDR = 3'd1, S_DUMMY = 3'd2, S_IGNORE = 3'd4;
  localparam int QUIET_AFTER = 8;

  logic [3:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hi_cnt <= '0;
    else if (!cs_n)                 hi_cnt <= '0;
    else if (hi_cnt != 4'hF)        hi_cnt <= hi_cnt + 4'd1;
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt >= 4'(QUIET_AFTER)) |-> !miso) else $error("idle miso high"); // R1

  AST_STABLE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck) && !cs_n) |-> $stable(miso)) else $error("miso moved while sck high"); // R9

  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGNORE) |-> !miso) else $error("miso active after unknown command"); // R6

  AST_PREDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD || st == S_ADDR || st == S_DUMMY) |-> !miso) else $error("miso active before data"); // R5

endmodule

bind spi_flash_responder spi_flash_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .miso(miso), .st(state)
);

// File: tb/tb_spi_flash_responder.sv
module tb_spi_flash_responder;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 6;
  localparam int NB = 256;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, pl_we = 1'b0;
  logic [7:0] pl_addr = '0, pl_data = '0;
  logic [7:0] model [NB];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  spi_flash_responder dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // opcode(8) address(24) byte count(8)
  localparam logic [39:0] VEC [7] = '{
    40'h03_000000_04, 40'h03_000011_03, 40'h0B_000020_03,
    40'h03_0000FE_04, 40'h0B_0000FF_02, 40'h03_ABCD07_02, 40'h03_000080_05
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r);
    mosi = b;
    wait_hp();
    sck = 1'b1;
    r = miso;
    wait_hp();
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] v, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) xbit(v[i], r[i]);
  endtask

  task automatic sel();
    @(negedge clk);
    cs_n = 1'b0;
    wait_hp();
  endtask

  task automatic desel();
    wait_hp();
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (3*HP) @(negedge clk);
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
    model[a] = d;
  endtask

  task automatic header(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] r;
    xbyte(op, r);
    xbyte(a[23:16], r);
    xbyte(a[15:8], r);
    xbyte(a[7:0], r);
  endtask

  task automatic do_read(input logic [7:0] op, input logic [23:0] a, input int n);
    logic [7:0] r;
    sel();
    header(op, a);
    if (op == 8'h0B) begin
      xbyte(8'h00, r);
      chk("R5 dummy byte quiet", r, 0);
    end
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, r);
      chk(k == 0 ? "R2 first byte" : "R3 sequential byte", r, model[(a + k) % NB]);
    end
    desel();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [31:0] acc;
    repeat (3) @(negedge clk);
    chk("R1 miso during reset", miso, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NB; i++) preload(i[7:0], 8'((i * 37 + 91) ^ (i >> 3)));
    chk("R1 miso idle after reset", miso, 0);

    // R2 R3 R4 R5 table walk
    foreach (VEC[v]) do_read(VEC[v][39:32], VEC[v][31:8], int'(VEC[v][7:0]));

    // R4 wrap and truncation explicit
    sel(); header(8'h03, 24'hFFFFFF);
    xbyte(8'h00, r); chk("R4 high bits truncated", r, model[8'hFF]);
    xbyte(8'h00, r); chk("R4 wrap to byte 0", r, model[0]);
    desel();

    // R6 unknown command stays silent then recovers
    sel(); xbyte(8'h9F, r);
    acc = '0;
    for (int i = 0; i < 4; i++) begin xbyte(8'h00, r); acc = {acc[23:0], r}; end
    chk("R6 silent after unknown command", acc, 0);
    desel();
    chk("R1 idle after deselect", miso, 0);
    do_read(8'h03, 24'h000042, 2);

    // R7 abort mid-byte then fresh transaction
    sel(); header(8'h03, 24'h000010);
    xbyte(8'h00, r); chk("R7 pre-abort byte", r, model[8'h10]);
    for (int i = 0; i < 3; i++) xbit(1'b0, r[0]);
    desel();
    chk("R1 miso low after abort", miso, 0);
    sel(); header(8'h03, 24'h000030);
    xbyte(8'h00, r); chk("R7 fresh start after abort", r, model[8'h30]);
    xbyte(8'h00, r); chk("R7 continues after abort", r, model[8'h31]);
    desel();

    // R8 preload overwrite
    preload(8'h40, 8'hA5);
    preload(8'h41, 8'h3C);
    do_read(8'h03, 24'h000040, 2);
    sel(); header(8'h0B, 24'h000040);
    xbyte(8'h00, r); chk("R5 dummy quiet", r, 0);
    xbyte(8'h00, r); chk("R8 overwritten byte", r, 8'hA5);
    desel();

    // R9 sampling at rise mid-phase: stable value checked over full high phase
    sel(); header(8'h03, 24'h000005);
    acc = '0;
    for (int i = 7; i >= 0; i--) begin
      mosi = 1'b0; wait_hp(); sck = 1'b1; r[0] = miso;
      repeat (HP - 1) @(negedge clk);
      if (miso !== r[0]) acc = acc + 1;
      @(negedge clk); sck = 1'b0;
    end
    chk("R9 miso stable while sck high", acc, 0);
    desel();

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule